// File: doc/BRIEF.md
# Four-channel receive DC offset canceller

This block sits on the receive sample path just after four ADC channels and strips DC from each of them. Channel 0 carries the in-phase and channel 1 the quadrature sample of the first receive side. Channels 2 and 3 do the same for the second side. Each channel first subtracts a programmable 16-bit static offset from the raw sample. An adaptive integrator then estimates whatever DC is left and subtracts it as well.

The integrator of each channel can be switched on or off on its own, through a masked write to a shared enable register. While its integrator is off, a channel applies only the static offset, and its accumulated estimate is frozen until the integrator is switched on again. All arithmetic saturates, so it never wraps.

Configuration arrives on a single-cycle write port. Samples arrive as four packed signed lanes that share one valid strobe.

Top module: `dco_offset_corr`

## Requirements
- R1: After reset, `out_valid_o` is 0, `out_data_o` is 0, all static offsets are 0 and the integrator of every channel is enabled.
- R2: Channel i takes its sample from `in_data_i[16*i+15:16*i]` and drives its result on `out_data_o[16*i+15:16*i]`. A write with `wr_addr_i` = i (0 to 3) loads `wr_data_i` as the signed static offset of channel i. With the integrator off, the result is the sample minus that offset.
- R3: Every subtraction is clamped to the range -32768 to 32767.
- R4: With the integrator of a channel on, the result is clamp(sample - offset) - (acc >>> 4), clamped again. Here acc is a signed 20-bit accumulator. On each valid sample, acc takes the value acc + result, clamped to 20 bits.
- R5: A write with `wr_addr_i` = 4 updates the enable bits. `wr_data_i[3:0]` gives the new enable values and `wr_data_i[11:8]` gives the mask. Enable bit i changes only when mask bit i is 1.
- R6: While the integrator of a channel is off, its accumulator keeps its value. When the integrator is switched on again, the channel resumes from the held estimate.
- R7: A result appears one clock after its input sample, and `out_valid_o` equals `in_valid_i` delayed by one clock. On cycles without a valid sample, `out_data_o` and the accumulators do not change. A write takes effect from the sample in the cycle after the write; a sample in the same cycle still uses the old settings.
- R8: Writes to addresses 5, 6 and 7 change no offset and no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0-3 are the offsets, 4 is the enable register |
| wr_data_i | input | 16 | Write data |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 64 | Four packed signed 16-bit samples, channel 0 in the low bits |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 64 | Four packed corrected samples |

## Verification
The hardest behaviour to observe from the ports is the frozen accumulator of a disabled channel, because a disabled channel's output does not depend on it. The stimulus first lets an integrator converge on one DC level. It then masks that integrator off and drives a different DC level for a while. Finally it masks the integrator back on, so the first corrected samples reveal whether the held estimate survived. Saturation is reached by pairing full-scale samples with full-scale offsets of the opposite sign.

// File: rtl/dco_pkg.sv
package dco_pkg;
  localparam int unsigned MASK_LSB = 8;

  function automatic longint clamp_s(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/dco_regs.sv
module dco_regs #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DW     = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DW-1:0]         wr_data_i,
  output logic [NCH*DW-1:0]     off_o,
  output logic [NCH-1:0]        en_o
);
  import dco_pkg::*;

  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(NCH);

  logic [NCH-1:0] en_bits, en_mask;
  assign en_bits = wr_data_i[NCH-1:0];
  assign en_mask = wr_data_i[MASK_LSB +: NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '1;
    else if (wr_en_i && wr_addr_i == EN_ADDR)
      en_o <= (en_o & ~en_mask) | (en_bits & en_mask);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_off
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) off_o[i*DW +: DW] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i))
        off_o[i*DW +: DW] <= wr_data_i;
    end
  end
endmodule

// File: rtl/dco_chan.sv
module dco_chan #(
  parameter int unsigned DW = 16,
  parameter int unsigned K  = 4,
  localparam int unsigned ACC_W = DW + K
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [DW-1:0]    x_i,
  input  logic signed [DW-1:0]    off_i,
  input  logic                    en_i,
  output logic signed [DW-1:0]    y_o,
  output logic signed [ACC_W-1:0] acc_o
);
  import dco_pkg::*;

  logic signed [DW-1:0]    stat_s, loop_s, y_n;
  logic signed [ACC_W-1:0] corr, acc_n;

  assign stat_s = DW'(clamp_s(longint'(x_i) - longint'(off_i), DW));
  assign corr   = acc_o >>> K;
  assign loop_s = DW'(clamp_s(longint'(stat_s) - longint'(corr), DW));
  assign y_n    = en_i ? loop_s : stat_s;
  assign acc_n  = ACC_W'(clamp_s(longint'(acc_o) + longint'(y_n), ACC_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o   <= '0;
      acc_o <= '0;
    end else if (valid_i) begin
      y_o <= y_n;
      if (en_i) acc_o <= acc_n;
    end
  end
endmodule

// File: rtl/dco_offset_corr.sv
module dco_offset_corr #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 16,
  parameter int unsigned K   = 4,
  localparam int unsigned ADDR_W = $clog2(NCH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              in_valid_i,
  input  logic [NCH*DW-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [NCH*DW-1:0] out_data_o
);
  localparam int unsigned ACC_W = DW + K;

  logic [NCH*DW-1:0]    off_w;
  logic [NCH-1:0]       en_w;
  logic [NCH*ACC_W-1:0] acc_w;

  dco_regs #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .off_o     (off_w),
    .en_o      (en_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dco_chan #(.DW(DW), .K(K)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (in_valid_i),
      .x_i     (in_data_i[i*DW +: DW]),
      .off_i   (off_w[i*DW +: DW]),
      .en_i    (en_w[i]),
      .y_o     (out_data_o[i*DW +: DW]),
      .acc_o   (acc_w[i*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= in_valid_i;
  end
endmodule

// File: rtl/dco_chk.sv
module dco_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DW     = 16,
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned ADDR_W = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic [NCH-1:0]        wr_mask_i,
  input logic                  in_valid_i,
  input logic                  out_valid_o,
  input logic [NCH*DW-1:0]     out_data_o,
  input logic [NCH-1:0]        en_w,
  input logic [NCH*ACC_W-1:0]  acc_w
);
  logic armed;
  logic en_wr;
  assign en_wr = wr_en_i && (wr_addr_i == ADDR_W'(NCH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (en_w == '1 && !out_valid_o && out_data_o == '0));

  a_r7_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> out_valid_o == $past(in_valid_i));

  a_r7_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(in_valid_i)) |-> $stable(out_data_o));

  a_r5_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(en_wr)) |-> $stable(en_w));

  a_r5_unmasked_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(en_wr)) |-> (((en_w ^ $past(en_w)) & ~$past(wr_mask_i)) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_acc
    a_r6_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !($past(in_valid_i) && $past(en_w[i])))
        |-> $stable(acc_w[i*ACC_W +: ACC_W]));
  end
endmodule

bind dco_offset_corr dco_chk #(
  .NCH(NCH), .DW(DW), .ACC_W(DW + K), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_mask_i   (wr_data_i[dco_pkg::MASK_LSB +: NCH]),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .en_w        (en_w),
  .acc_w       (acc_w)
);

// File: tb/tb_dco_offset_corr.sv
`timescale 1ns/1ps
module tb_dco_offset_corr;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int K   = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en_i = 1'b0;
  logic [2:0]      wr_addr_i = '0;
  logic [15:0]     wr_data_i = '0;
  logic            in_valid_i = 1'b0;
  logic [63:0]     in_data_i = '0;
  logic            out_valid_o;
  logic [63:0]     out_data_o;

  dco_offset_corr dut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int  m_off[NCH];
  bit  m_en[NCH];
  int  m_acc[NCH];
  int  exp_y[NCH];
  bit  exp_v;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int sat(int v, int w);
    int hi = (1 <<< (w - 1)) - 1;
    int lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int s16(logic [15:0] v);
    return int'(signed'(v));
  endfunction

  task automatic compare(string tag);
    checks++;
    if (out_valid_o !== exp_v) begin
      errors++;
      $display("FAIL %s valid act=%0d exp=%0d", tag, out_valid_o, exp_v);
    end
    for (int i = 0; i < NCH; i++) begin
      checks++;
      if (s16(out_data_o[i*16 +: 16]) !== exp_y[i]) begin
        errors++;
        $display("FAIL %s ch%0d act=%0d exp=%0d", tag, i,
                 s16(out_data_o[i*16 +: 16]), exp_y[i]);
      end
    end
  endtask

  task automatic cyc(bit v, int d0, int d1, int d2, int d3,
                     bit we, int addr, int wd, string tag);
    int d[NCH];
    int s1, y;
    logic [15:0] w;
    d = '{d0, d1, d2, d3};
    @(negedge clk_i);
    compare(tag);
    in_valid_i = v;
    for (int i = 0; i < NCH; i++) in_data_i[i*16 +: 16] = 16'(d[i]);
    wr_en_i = we;
    wr_addr_i = 3'(addr);
    wr_data_i = 16'(wd);
    if (v) begin
      for (int i = 0; i < NCH; i++) begin
        s1 = sat(d[i] - m_off[i], 16);
        if (m_en[i]) begin
          y = sat(s1 - (m_acc[i] >>> K), 16);
          m_acc[i] = sat(m_acc[i] + y, DW + K);
        end else y = s1;
        exp_y[i] = y;
      end
    end
    exp_v = v;
    if (we) begin
      w = 16'(wd);
      if (addr < NCH) m_off[addr] = s16(w);
      else if (addr == NCH)
        for (int i = 0; i < NCH; i++)
          if (w[8 + i]) m_en[i] = w[i];
    end
  endtask

  task automatic smp(int d0, int d1, int d2, int d3, string tag);
    cyc(1, d0, d1, d2, d3, 0, 0, 0, tag);
  endtask

  task automatic wr(int addr, int wd, string tag);
    cyc(0, 0, 0, 0, 0, 1, addr, wd, tag);
  endtask

  function automatic int rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return s16(lfsr) >>> 1;
  endfunction

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_off[i] = 0; m_en[i] = 1; m_acc[i] = 0; exp_y[i] = 0;
    end
    exp_v = 0;
    #12 rst_ni = 1'b1;

    // R1: reset values, then integrators active by default
    for (int n = 0; n < 40; n++) smp(500, -700, 1500, -20, "R1");

    // R2: integrators off, static offsets per lane
    wr(4, 16'h0F00, "R2");
    wr(0, 100, "R2"); wr(1, -200, "R2"); wr(2, 3000, "R2"); wr(3, -4000, "R2");
    for (int n = 0; n < 20; n++) smp(rnd(), rnd(), rnd(), rnd(), "R2");

    // R3: clamping at both rails
    wr(0, 16'h8000, "R3"); wr(1, 16'h7FFF, "R3"); wr(2, 1, "R3"); wr(3, -1, "R3");
    for (int n = 0; n < 4; n++) smp(32767, -32768, -32768, 32767, "R3");
    smp(-5, 5, 10, -10, "R3");

    // R4: integrators on for lanes 0 and 2 only
    for (int a = 0; a < NCH; a++) wr(a, 0, "R4");
    wr(4, 16'h0505, "R4");
    for (int n = 0; n < 60; n++) smp(1200, -900, -2500, 3333, "R4");

    // R5: mask touches lane 1 only although all bits are set
    wr(4, 16'h020F, "R5");
    for (int n = 0; n < 30; n++) smp(1200, -900, -2500, 3333, "R5");

    // R6: freeze lane 0, change its DC, then resume
    wr(4, 16'h0100, "R6");
    for (int n = 0; n < 20; n++) smp(-8000, -900, -2500, 3333, "R6");
    wr(4, 16'h0101, "R6");
    for (int n = 0; n < 20; n++) smp(1200, -900, -2500, 3333, "R6");

    // R7: gapped valid, write concurrent with samples
    for (int n = 0; n < 80; n++) begin
      bit v = lfsr[3];
      if (n % 17 == 5) cyc(v, rnd(), rnd(), rnd(), rnd(), 1, n % 4, rnd(), "R7");
      else             cyc(v, rnd(), rnd(), rnd(), rnd(), 0, 0, 0, "R7");
    end

    // R8: unused addresses
    wr(5, 16'hFFFF, "R8"); wr(6, 16'hFFFF, "R8"); wr(7, 16'h0F00, "R8");
    for (int n = 0; n < 20; n++) smp(rnd(), rnd(), rnd(), rnd(), "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    @(negedge clk_i);
    compare("R8");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule